// File: doc/BRIEF.md
# Sensor-Scan Interrupt Flag Controller

This block gathers nine event sources from a sensor-scan peripheral and turns each one into a sticky interrupt flag. Each flag has its own enable bit. A single interrupt request line goes high when at least one enabled flag is pending and the global interrupt enable input is high. A vector register reports which pending source should be serviced first. The lowest-numbered enabled flag has the highest priority.

The sources are of three kinds:
- **Scan outputs.** Two flags each watch one of four scan outputs, picked by a select field.
- **Sequencer signals.** A start pulse, and a stop level whose rising edge is the event.
- **Counter and state-machine events.** Three counter interval pulses, plus a state-machine update strobe with the next-state bits. Two flags fire on each step into a state with a given bit set.

Software works through a small register port:
- Enable and select registers can be written and read back.
- Flags are cleared by writing ones to the flag register.
- Flags can be forced on by writing ones to a set register.
- The vector can be read without side effects. Hardware never clears a flag.

Top module: `scan_irq_ctrl`

## Requirements
- R1: After reset, all flags, enables and select fields are 0, `irq` is low, and every register reads 0.
- R2: Flag bit n is register bit n. Once set, a flag stays set until software clears it. Sources:
  - flag 2: `seq_start`
  - flag 3: `cnt_evt[0]`
  - flag 4: `cnt_evt[1]`
  - flag 7: `cnt_evt[2]`
- R3: The select register (address 3) holds two fields:
  - Bits [1:0] pick which of `scan_out[3:0]` sets flag 0.
  - Bits [3:2] pick which of `scan_out[7:4]` sets flag 8.
  - Outputs that are not selected have no effect.
- R4: Flag 1 is set only on a rising edge of `seq_stop`. If the stop level stays high after software clears the flag, the flag stays clear.
- R5: In a cycle with `psm_step` high:
  - `psm_next[6]` high sets flag 5.
  - `psm_next[7]` high sets flag 6.
  - Without `psm_step`, these bits set nothing.
- R6: `irq` is high exactly when `gie` is high and some flag is set whose enable bit (register at address 0, bit n) is also set.
- R7: The vector register (address 4) reads as follows:
  - 0 when no enabled flag is pending.
  - Otherwise 2×(n+1), where n is the lowest-numbered enabled pending flag.
- R8: Reading the vector register does not change any flag.
- R9: Writing ones to the flag register (address 1) clears exactly those flags. If a source event hits a flag in the same cycle as its clear, the flag ends up set.
- R10: Writing ones to the set register (address 2) sets exactly those flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gie | input | 1 | Global interrupt enable |
| scan_out | input | 8 | Scan output levels |
| seq_start | input | 1 | Sequencer run start pulse |
| seq_stop | input | 1 | Sequencer stop level |
| cnt_evt | input | 3 | Counter interval events (flags 3, 4, 7) |
| psm_step | input | 1 | State machine update strobe |
| psm_next | input | 8 | Next-state bits of the state machine |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
A vector table drives each source alone, one per cycle, and compares the flag register with the one bit expected. Several entries drive a scan output that the select field does not pick, or give state bits without a step strobe. This separates a correct source-to-flag mapping from one that decodes too broadly.

Directed sequences cover the remaining behaviour:
- A stop level is held high across a clear, which tells edge detection apart from level sensing.
- Different mixes of pending flags and enable masks distinguish the priority order from a plain OR.
- A clear is written in the same cycle as an event, which shows which of the two wins.

// File: rtl/scan_irq_pkg.sv
`timescale 1ns/1ps
package scan_irq_pkg;
  localparam int NFLAG  = 9;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 16;

  // register addresses
  localparam logic [ADDR_W-1:0] A_EN   = 3'd0;
  localparam logic [ADDR_W-1:0] A_FLAG = 3'd1;
  localparam logic [ADDR_W-1:0] A_SET  = 3'd2;
  localparam logic [ADDR_W-1:0] A_SEL  = 3'd3;
  localparam logic [ADDR_W-1:0] A_VEC  = 3'd4;

  // flag positions (priority follows index)
  localparam int F_OUTLO = 0;
  localparam int F_STOP  = 1;
  localparam int F_START = 2;
  localparam int F_CNTA  = 3;
  localparam int F_CNTB  = 4;
  localparam int F_ST6   = 5;
  localparam int F_ST7   = 6;
  localparam int F_CNTC  = 7;
  localparam int F_OUTHI = 8;

  localparam int ST_BIT_A = 6;
  localparam int ST_BIT_B = 7;

  // vector code: 0 if nothing pending, else 2*(n+1) for lowest pending n
  function automatic logic [DATA_W-1:0] vec_code(input logic [NFLAG-1:0] pend);
    logic [DATA_W-1:0] r;
    r = '0;
    for (int i = NFLAG - 1; i >= 0; i--) begin
      if (pend[i]) r = DATA_W'(2 * (i + 1));
    end
    return r;
  endfunction
endpackage

// File: rtl/scan_irq_events.sv
`timescale 1ns/1ps
module scan_irq_events
  import scan_irq_pkg::*;
#(
  parameter int SCAN_W = 8,
  parameter int CNT_N  = 3,
  parameter int ST_W   = 8,
  localparam int HALF  = SCAN_W / 2,
  localparam int SEL_W = $clog2(HALF)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SCAN_W-1:0] scan_out,
  input  logic [SEL_W-1:0]  sel_lo,
  input  logic [SEL_W-1:0]  sel_hi,
  input  logic              seq_start,
  input  logic              seq_stop,
  input  logic [CNT_N-1:0]  cnt_evt,
  input  logic              psm_step,
  input  logic [ST_W-1:0]   psm_next,
  output logic [NFLAG-1:0]  ev
);
  logic stop_q;
  logic stop_rise;
  logic [SEL_W:0] hi_idx;
  logic unused_state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stop_q <= 1'b0;
    else        stop_q <= seq_stop;
  end

  assign stop_rise    = seq_stop & ~stop_q;
  assign hi_idx       = {1'b1, sel_hi};
  assign unused_state = ^psm_next;

  always_comb begin
    ev          = '0;
    ev[F_OUTLO] = scan_out[sel_lo];
    ev[F_OUTHI] = scan_out[hi_idx];
    ev[F_STOP]  = stop_rise;
    ev[F_START] = seq_start;
    ev[F_CNTA]  = cnt_evt[0];
    ev[F_CNTB]  = cnt_evt[1];
    ev[F_CNTC]  = cnt_evt[2];
    ev[F_ST6]   = psm_step & psm_next[ST_BIT_A];
    ev[F_ST7]   = psm_step & psm_next[ST_BIT_B];
  end
endmodule

// File: rtl/scan_irq_flags.sv
`timescale 1ns/1ps
module scan_irq_flags
  import scan_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] ev,
  input  logic [NFLAG-1:0] clr,
  input  logic [NFLAG-1:0] set,
  output logic [NFLAG-1:0] flags
);
  for (genvar k = 0; k < NFLAG; k++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags[k] <= 1'b0;
      else        flags[k] <= (flags[k] & ~clr[k]) | ev[k] | set[k];
    end
  end
endmodule

// File: rtl/scan_irq_prio.sv
`timescale 1ns/1ps
module scan_irq_prio
  import scan_irq_pkg::*;
(
  input  logic [NFLAG-1:0]  flags,
  input  logic [NFLAG-1:0]  en,
  output logic [DATA_W-1:0] vec,
  output logic              any
);
  logic [NFLAG-1:0] pend;
  assign pend = flags & en;
  assign vec  = vec_code(pend);
  assign any  = |pend;
endmodule

// File: rtl/scan_irq_regs.sv
`timescale 1ns/1ps
module scan_irq_regs
  import scan_irq_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NFLAG-1:0]  flags,
  input  logic [DATA_W-1:0] vec,
  output logic [NFLAG-1:0]  en,
  output logic [SEL_W-1:0]  sel_lo,
  output logic [SEL_W-1:0]  sel_hi,
  output logic [NFLAG-1:0]  clr_mask,
  output logic [NFLAG-1:0]  set_mask,
  output logic [DATA_W-1:0] rdata
);
  logic unused_wdata;
  assign unused_wdata = ^wdata[DATA_W-1:NFLAG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en     <= '0;
      sel_lo <= '0;
      sel_hi <= '0;
    end else if (wr) begin
      if (addr == A_EN) en <= wdata[NFLAG-1:0];
      if (addr == A_SEL) begin
        sel_lo <= wdata[SEL_W-1:0];
        sel_hi <= wdata[2*SEL_W-1:SEL_W];
      end
    end
  end

  assign clr_mask = (wr && addr == A_FLAG) ? wdata[NFLAG-1:0] : '0;
  assign set_mask = (wr && addr == A_SET)  ? wdata[NFLAG-1:0] : '0;

  always_comb begin
    rdata = '0;
    case (addr)
      A_EN:    rdata[NFLAG-1:0]   = en;
      A_FLAG:  rdata[NFLAG-1:0]   = flags;
      A_SEL:   rdata[2*SEL_W-1:0] = {sel_hi, sel_lo};
      A_VEC:   rdata              = vec;
      default: rdata              = '0;
    endcase
  end
endmodule

// File: rtl/scan_irq_ctrl.sv
`timescale 1ns/1ps
module scan_irq_ctrl
  import scan_irq_pkg::*;
#(
  parameter int SCAN_W = 8,
  parameter int CNT_N  = 3,
  parameter int ST_W   = 8,
  localparam int SEL_W = $clog2(SCAN_W / 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gie,
  input  logic [SCAN_W-1:0] scan_out,
  input  logic              seq_start,
  input  logic              seq_stop,
  input  logic [CNT_N-1:0]  cnt_evt,
  input  logic              psm_step,
  input  logic [ST_W-1:0]   psm_next,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  logic [NFLAG-1:0]  ev_set;
  logic [NFLAG-1:0]  clr_mask;
  logic [NFLAG-1:0]  set_mask;
  logic [NFLAG-1:0]  flags_q;
  logic [NFLAG-1:0]  en_q;
  logic [SEL_W-1:0]  sel_lo;
  logic [SEL_W-1:0]  sel_hi;
  logic [DATA_W-1:0] vec_w;
  logic              any_pend;

  scan_irq_events #(.SCAN_W(SCAN_W), .CNT_N(CNT_N), .ST_W(ST_W)) u_events (
    .clk(clk), .rst_n(rst_n), .scan_out(scan_out), .sel_lo(sel_lo), .sel_hi(sel_hi),
    .seq_start(seq_start), .seq_stop(seq_stop), .cnt_evt(cnt_evt),
    .psm_step(psm_step), .psm_next(psm_next), .ev(ev_set)
  );

  scan_irq_flags u_flags (
    .clk(clk), .rst_n(rst_n), .ev(ev_set), .clr(clr_mask), .set(set_mask), .flags(flags_q)
  );

  scan_irq_prio u_prio (
    .flags(flags_q), .en(en_q), .vec(vec_w), .any(any_pend)
  );

  scan_irq_regs #(.SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .flags(flags_q), .vec(vec_w), .en(en_q), .sel_lo(sel_lo), .sel_hi(sel_hi),
    .clr_mask(clr_mask), .set_mask(set_mask), .rdata(reg_rdata)
  );

  assign irq = gie & any_pend;
endmodule

// File: rtl/scan_irq_ctrl_chk.sv
`timescale 1ns/1ps
module scan_irq_ctrl_chk
  import scan_irq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              gie,
  input logic              irq,
  input logic              seq_stop,
  input logic              psm_step,
  input logic [NFLAG-1:0]  flags,
  input logic [NFLAG-1:0]  en,
  input logic [NFLAG-1:0]  ev,
  input logic [NFLAG-1:0]  clr,
  input logic [DATA_W-1:0] vec
);
  logic [3:0]       idx;
  logic [NFLAG-1:0] below;
  assign idx   = vec[4:1] - 4'd1;
  assign below = (NFLAG'(1) << idx) - NFLAG'(1);

  // R6: no request without global enable
  assert_irq_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> !irq);

  // R2: a set flag not cleared stays set
  assert_flag_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(flags) & ~$past(clr)) & ~flags) == '0));

  // R9: an event always lands, even with a clear in the same cycle
  assert_event_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev != '0) |=> ((flags & $past(ev)) == $past(ev)));

  // R4: held stop level produces no event
  assert_stop_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_stop && $past(seq_stop)) |-> !ev[F_STOP]);

  // R5: state bits need the step strobe
  assert_state_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !psm_step |-> (!ev[F_ST6] && !ev[F_ST7]));

  // R7: zero vector when nothing enabled is pending
  assert_vec_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & en) == '0) |-> (vec == '0));

  // R7: nonzero vector names a pending enabled flag with none lower
  assert_vec_prio_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (vec != '0) |-> (flags[idx] && en[idx] && ((flags & en & below) == '0)));
endmodule

bind scan_irq_ctrl scan_irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .gie(gie), .irq(irq), .seq_stop(seq_stop),
  .psm_step(psm_step), .flags(flags_q), .en(en_q), .ev(ev_set),
  .clr(clr_mask), .vec(vec_w)
);

// File: tb/scan_irq_ctrl_tb.sv
`timescale 1ns/1ps
module scan_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        gie = 1'b0;
  logic [7:0]  scan_out = '0;
  logic        seq_start = 1'b0;
  logic        seq_stop = 1'b0;
  logic [2:0]  cnt_evt = '0;
  logic        psm_step = 1'b0;
  logic [7:0]  psm_next = '0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  scan_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .gie(gie), .scan_out(scan_out), .seq_start(seq_start),
    .seq_stop(seq_stop), .cnt_evt(cnt_evt), .psm_step(psm_step), .psm_next(psm_next),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  typedef struct packed {
    logic [1:0] slo;
    logic [1:0] shi;
    logic [7:0] so;
    logic       st;
    logic       sp;
    logic [2:0] ce;
    logic       stp;
    logic [7:0] nx;
    logic [8:0] exp;
  } vec_t;

  localparam logic [34:0] TBL [12] = '{
    {2'd0, 2'd0, 8'h01, 1'b0, 1'b0, 3'b000, 1'b0, 8'h00, 9'h001}, // R3
    {2'd2, 2'd0, 8'h04, 1'b0, 1'b0, 3'b000, 1'b0, 8'h00, 9'h001}, // R3
    {2'd1, 2'd0, 8'h04, 1'b0, 1'b0, 3'b000, 1'b0, 8'h00, 9'h000}, // R3 unselected
    {2'd0, 2'd2, 8'h40, 1'b0, 1'b0, 3'b000, 1'b0, 8'h00, 9'h100}, // R3
    {2'd0, 2'd0, 8'h40, 1'b0, 1'b0, 3'b000, 1'b0, 8'h00, 9'h000}, // R3 unselected
    {2'd0, 2'd0, 8'h00, 1'b0, 1'b1, 3'b000, 1'b0, 8'h00, 9'h002}, // R4
    {2'd0, 2'd0, 8'h00, 1'b1, 1'b0, 3'b000, 1'b0, 8'h00, 9'h004}, // R2
    {2'd0, 2'd0, 8'h00, 1'b0, 1'b0, 3'b111, 1'b0, 8'h00, 9'h098}, // R2
    {2'd0, 2'd0, 8'h00, 1'b0, 1'b0, 3'b000, 1'b1, 8'h40, 9'h020}, // R5
    {2'd0, 2'd0, 8'h00, 1'b0, 1'b0, 3'b000, 1'b1, 8'hC0, 9'h060}, // R5
    {2'd0, 2'd0, 8'h00, 1'b0, 1'b0, 3'b000, 1'b0, 8'hC0, 9'h000}, // R5 no step
    {2'd3, 2'd3, 8'hFF, 1'b0, 1'b0, 3'b000, 1'b0, 8'h3F, 9'h101}  // R3
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [15:0] v;
    logic [15:0] v2;
    vec_t t;
    repeat (3) @(negedge clk);
    // R1 reset state
    #1 check("R1 irq", {15'd0, irq}, 16'd0);
    rd(3'd0, v); check("R1 enable", v, 16'h0);
    rd(3'd1, v); check("R1 flags", v, 16'h0);
    rd(3'd3, v); check("R1 select", v, 16'h0);
    rd(3'd4, v); check("R1 vector", v, 16'h0);
    @(negedge clk); rst_n = 1'b1;
    rd(3'd1, v); check("R1 flags after release", v, 16'h0);

    // table walk
    for (int i = 0; i < 12; i++) begin
      t = vec_t'(TBL[i]);
      wr(3'd3, {12'd0, t.shi, t.slo});
      wr(3'd1, 16'h01FF);
      @(negedge clk);
      scan_out = t.so; seq_start = t.st; seq_stop = t.sp;
      cnt_evt = t.ce; psm_step = t.stp; psm_next = t.nx;
      @(negedge clk);
      scan_out = '0; seq_start = 0; seq_stop = 0; cnt_evt = '0; psm_step = 0; psm_next = '0;
      rd(3'd1, v);
      check($sformatf("R2/R3/R4/R5 table row %0d", i), v, {7'd0, t.exp});
    end
    wr(3'd3, 16'h0);

    // R4 held stop level
    wr(3'd1, 16'h01FF);
    @(negedge clk); seq_stop = 1'b1;
    repeat (3) @(negedge clk);
    rd(3'd1, v); check("R4 edge sets", v, 16'h002);
    wr(3'd1, 16'h0002);
    repeat (3) @(negedge clk);
    rd(3'd1, v); check("R4 held level no reset", v, 16'h000);
    @(negedge clk); seq_stop = 1'b0;
    @(negedge clk); seq_stop = 1'b1;
    @(negedge clk); seq_stop = 1'b0;
    rd(3'd1, v); check("R4 new edge", v, 16'h002);

    // R10 set, R6 gating
    wr(3'd1, 16'h01FF);
    gie = 1'b1;
    wr(3'd2, 16'h0008);
    rd(3'd1, v); check("R10 set flag3", v, 16'h008);
    #1 check("R6 disabled", {15'd0, irq}, 16'd0);
    wr(3'd0, 16'h0008);
    gie = 1'b0;
    #1 check("R6 gie low", {15'd0, irq}, 16'd0);
    gie = 1'b1;
    #1 check("R6 asserted", {15'd0, irq}, 16'd1);
    wr(3'd0, 16'h0010);
    #1 check("R6 other enable only", {15'd0, irq}, 16'd0);

    // R7 priority
    wr(3'd2, 16'h0020);
    wr(3'd0, 16'h01FF);
    rd(3'd4, v); check("R7 lowest of 3,5", v, 16'd8);
    wr(3'd0, 16'h0020);
    rd(3'd4, v); check("R7 only 5 enabled", v, 16'd12);
    wr(3'd0, 16'h0000);
    rd(3'd4, v); check("R7 none enabled", v, 16'd0);
    wr(3'd2, 16'h0101);
    wr(3'd0, 16'h01FF);
    rd(3'd4, v); check("R7 flag0 top", v, 16'd2);
    wr(3'd0, 16'h0100);
    rd(3'd4, v); check("R7 flag8", v, 16'd18);

    // R8 vector read no side effect
    rd(3'd4, v); rd(3'd4, v2);
    check("R8 repeat read", v2, v);
    rd(3'd1, v); check("R8 flags kept", v, 16'h129);

    // R9 partial clear and collision
    wr(3'd1, 16'h0008);
    rd(3'd1, v); check("R9 partial clear", v, 16'h121);
    @(negedge clk);
    cnt_evt = 3'b001; reg_addr = 3'd1; reg_wdata = 16'h0008; reg_wr = 1'b1;
    @(negedge clk);
    cnt_evt = '0; reg_wr = 1'b0;
    rd(3'd1, v); check("R9 event beats clear", v, 16'h129);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule